// File: doc/BRIEF.md
# Reloadable 8-bit Interval Timer

This block is a programmable interval timer for a small host bus. A free-running prescaler divides the system clock by one of eight powers of two. Each divided period gives a one-cycle count-enable tick. An enable bit gates those ticks. An 8-bit down-counter consumes the ticks while it is running. When the counter steps past zero, it loads the value in a reload register. At the same time it emits a one-cycle underflow pulse and toggles a square-wave output.

Software uses four byte-wide locations through a simple address/data/write/read interface:

- Address 0 holds the clock setup: a rate code in bits 2:0 and the tick enable in bit 3.
- Address 1 holds the control bits: run in bit 0, a write-only restart strobe in bit 1, and the output enable in bit 2.
- Address 2 holds the reload value.
- Address 3 returns a buffered copy of the count. The copy stays frozen while it is being read.

Top module: `tmr8_top`

## Requirements
- R1: After reset: address 0 reads 0x00, address 1 reads 0x00, address 2 reads 0xFF, address 3 reads 0xFF, and `uf_pulse` and `tmr_out` are 0.
- R2: With rate code k (bits 2:0 of address 0), ticks are spaced 2^(k+1) system clocks apart. While running, consecutive underflow pulses are (reload+1)·2^(k+1) clocks apart.
- R3: While the tick enable (address 0 bit 3) is 0, the count does not change, even when running.
- R4: While run (address 1 bit 0) is 0, the count does not change, even with ticks enabled.
- R5: A tick that arrives at count 0x00 loads the reload value instead of wrapping to 0xFF. It also raises `uf_pulse` for exactly one cycle.
- R6: Writing address 1 with bit 1 set copies the reload value into the counter on that clock edge. Writing bit 1 as 0 leaves the count unchanged. Bit 1 always reads 0.
- R7: A restart issued while running resumes counting from the newly loaded value. The next underflow follows reload+1 ticks later.
- R8: While `bus_re` is held on address 3, `bus_rdata` stays constant, even when the counter moves. Otherwise the buffer follows the count one clock behind.
- R9: `tmr_out` toggles on every underflow when the output enable (address 1 bit 2) is 1. It is held at 0 while that bit is 0.
- R10: Unused bits read as 0: bits 7:4 of address 0, and bits 7:3 and bit 1 of address 1. The written bits read back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 2 | Register location |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, one clock per write |
| bus_re | input | 1 | Read qualifier, freezes the count buffer on address 3 |
| bus_rdata | output | 8 | Read data, combinational from the addressed location |
| uf_pulse | output | 1 | One-cycle underflow indication |
| tmr_out | output | 1 | Toggling timer output, gated by the output enable |

## Verification
The bench builds the block with its default widths: an 8-bit count and a 3-bit rate code, which give an 8-bit prescaler. At these widths every one of the eight division ratios fits inside a few hundred clocks per underflow. The bench therefore sweeps all of them, measuring the underflow spacing against (reload+1)·2^(k+1). The small reload values also let it reach the zero-crossing reload, a restart during counting, and the buffer freeze within a short run.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;
    localparam int CNT_W = 8;
    localparam int SEL_W = 3;
    localparam int PRE_W = 1 << SEL_W;
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] A_CLK  = 2'd0;
    localparam logic [ADDR_W-1:0] A_CTRL = 2'd1;
    localparam logic [ADDR_W-1:0] A_RLD  = 2'd2;
    localparam logic [ADDR_W-1:0] A_CNT  = 2'd3;

    localparam int B_RUN  = 0;
    localparam int B_PSET = 1;
    localparam int B_OEN  = 2;
    localparam int B_CEN  = SEL_W;

    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic             clk_en;
        logic             run;
        logic             out_en;
        logic [CNT_W-1:0] reload;
        logic [CNT_W-1:0] snap;
    } regs_t;

    typedef struct packed {
        logic [PRE_W-1:0] cnt;
        logic             tick;
    } pre_t;

    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic             uf;
        logic             tog;
    } core_t;
endpackage

// File: rtl/tmr8_prescale.sv
module tmr8_prescale
    import tmr8_pkg::*;
#(
    parameter int SW = SEL_W,
    localparam int PW = 1 << SW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [SW-1:0] sel,
    input  logic          enable,
    output logic          tick
);
    logic [PW-1:0] cnt_d, cnt_q;
    logic          tick_d, tick_q;

    always_comb begin
        cnt_d  = cnt_q + 1'b1;
        // rising edge of the selected divider bit
        tick_d = enable && !cnt_q[sel] && cnt_d[sel];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            tick_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_d;
            tick_q <= tick_d;
        end
    end

    assign tick = tick_q;
endmodule

// File: rtl/tmr8_core.sv
module tmr8_core
    import tmr8_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         run,
    input  logic         preset,
    input  logic [W-1:0] reload,
    output logic [W-1:0] count,
    output logic         uf,
    output logic         tog
);
    logic [W-1:0] count_d, count_q;
    logic         uf_d, uf_q;
    logic         tog_d, tog_q;

    always_comb begin
        count_d = count_q;
        uf_d    = 1'b0;
        tog_d   = tog_q;
        if (preset) begin
            count_d = reload;
        end else if (run && tick) begin
            if (count_q == '0) begin
                count_d = reload;
                uf_d    = 1'b1;
                tog_d   = !tog_q;
            end else begin
                count_d = count_q - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '1;
            uf_q    <= 1'b0;
            tog_q   <= 1'b0;
        end else begin
            count_q <= count_d;
            uf_q    <= uf_d;
            tog_q   <= tog_d;
        end
    end

    assign count = count_q;
    assign uf    = uf_q;
    assign tog   = tog_q;
endmodule

// File: rtl/tmr8_regs.sv
module tmr8_regs
    import tmr8_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  wdata,
    input  logic              we,
    input  logic              re,
    output logic [CNT_W-1:0]  rdata,
    input  logic [CNT_W-1:0]  count,
    output logic [SEL_W-1:0]  sel,
    output logic              clk_en,
    output logic              run,
    output logic              out_en,
    output logic              preset,
    output logic [CNT_W-1:0]  reload
);
    regs_t r_d, r_q;
    logic  cnt_read;

    always_comb begin
        r_d      = r_q;
        cnt_read = re && (addr == A_CNT);
        preset   = we && (addr == A_CTRL) && wdata[B_PSET];
        if (we) begin
            unique case (addr)
                A_CLK: begin
                    r_d.sel    = wdata[SEL_W-1:0];
                    r_d.clk_en = wdata[B_CEN];
                end
                A_CTRL: begin
                    r_d.run    = wdata[B_RUN];
                    r_d.out_en = wdata[B_OEN];
                end
                A_RLD:   r_d.reload = wdata;
                default: ;
            endcase
        end
        if (!cnt_read) r_d.snap = count;

        rdata = '0;
        unique case (addr)
            A_CLK: begin
                rdata[SEL_W-1:0] = r_q.sel;
                rdata[B_CEN]     = r_q.clk_en;
            end
            A_CTRL: begin
                rdata[B_RUN] = r_q.run;
                rdata[B_OEN] = r_q.out_en;
            end
            A_RLD:   rdata = r_q.reload;
            default: rdata = r_q.snap;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.sel    <= '0;
            r_q.clk_en <= 1'b0;
            r_q.run    <= 1'b0;
            r_q.out_en <= 1'b0;
            r_q.reload <= '1;
            r_q.snap   <= '1;
        end else begin
            r_q <= r_d;
        end
    end

    assign sel    = r_q.sel;
    assign clk_en = r_q.clk_en;
    assign run    = r_q.run;
    assign out_en = r_q.out_en;
    assign reload = r_q.reload;
endmodule

// File: rtl/tmr8_top.sv
module tmr8_top
    import tmr8_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    input  logic              bus_we,
    input  logic              bus_re,
    output logic [CNT_W-1:0]  bus_rdata,
    output logic              uf_pulse,
    output logic              tmr_out
);
    logic [SEL_W-1:0] sel;
    logic             clk_en, run, out_en, preset, tick, tog;
    logic [CNT_W-1:0] reload, count;

    tmr8_regs u_regs (
        .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wdata(bus_wdata),
        .we(bus_we), .re(bus_re), .rdata(bus_rdata), .count(count),
        .sel(sel), .clk_en(clk_en), .run(run), .out_en(out_en),
        .preset(preset), .reload(reload)
    );

    tmr8_prescale #(.SW(SEL_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .sel(sel), .enable(clk_en), .tick(tick)
    );

    tmr8_core #(.W(CNT_W)) u_core (
        .clk(clk), .rst_n(rst_n), .tick(tick), .run(run), .preset(preset),
        .reload(reload), .count(count), .uf(uf_pulse), .tog(tog)
    );

    assign tmr_out = out_en & tog;
endmodule

// File: rtl/tmr8_chk.sv
module tmr8_chk
    import tmr8_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_re,
    input logic [CNT_W-1:0]  bus_rdata,
    input logic              tick,
    input logic              clk_en,
    input logic              run,
    input logic              preset,
    input logic              out_en,
    input logic [CNT_W-1:0]  count,
    input logic [CNT_W-1:0]  reload,
    input logic              uf_pulse,
    input logic              tmr_out
);
    logic cnt_rd;
    assign cnt_rd = bus_re && (bus_addr == A_CNT);

    // R2: ticks never arrive back to back
    p_tick_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

    // R3: no ticks while the tick enable is low
    p_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |=> !tick);

    // R4: a stopped counter only moves by restart
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !preset) |=> $stable(count));

    // R5: underflow lands on the reload value and lasts one cycle
    p_uf_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        uf_pulse |-> count == reload);
    p_uf_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        uf_pulse |=> !uf_pulse);

    // R6: restart copies the reload value
    p_preset_r6: assert property (@(posedge clk) disable iff (!rst_n)
        preset |=> count == $past(reload));

    // R8: buffered read stays frozen across a held read
    p_snap_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_rd && $past(cnt_rd)) |-> $stable(bus_rdata));

    // R9: output held low while disabled
    p_out_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !out_en |-> !tmr_out);
endmodule

bind tmr8_top tmr8_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_re(bus_re),
    .bus_rdata(bus_rdata), .tick(tick), .clk_en(clk_en), .run(run),
    .preset(preset), .out_en(out_en), .count(count), .reload(reload),
    .uf_pulse(uf_pulse), .tmr_out(tmr_out)
);

// File: tb/tb_tmr8_top.sv
module tb_tmr8_top;
    localparam int TCLK = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic       bus_we = 1'b0;
    logic       bus_re = 1'b0;
    logic [7:0] bus_rdata;
    logic       uf_pulse, tmr_out;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    tmr8_top dut (.*);

    always #(TCLK/2) clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_re = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_re = 1'b0;
    endtask

    task automatic wait_uf();
        do @(negedge clk); while (!uf_pulse);
    endtask

    task automatic uf_gap(output int n);
        n = 0;
        do begin @(negedge clk); n++; end while (!uf_pulse);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : stim
        logic [7:0] v, v2;
        int n;
        bit o1, o2;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(2'd0, v); check("R1 clk reg", v, 8'h00);
        rd(2'd1, v); check("R1 ctrl reg", v, 8'h00);
        rd(2'd2, v); check("R1 reload", v, 8'hFF);
        rd(2'd3, v); check("R1 count", v, 8'hFF);
        check("R1 uf", uf_pulse, 0);
        check("R1 out", tmr_out, 0);

        // R10 readback and unused bits
        wr(2'd0, 8'hFF); rd(2'd0, v); check("R10 clk reg", v, 8'h0F);
        wr(2'd0, 8'h00);
        wr(2'd2, 8'h20);
        wr(2'd1, 8'hFE); rd(2'd1, v); check("R10 ctrl reg", v, 8'h04);

        // R6 preset loads, write of 0 ignored, reads 0
        rd(2'd3, v); check("R6 preset load", v, 8'h20);
        wr(2'd2, 8'h30);
        wr(2'd1, 8'h00);
        repeat (2) @(negedge clk);
        rd(2'd3, v); check("R6 zero write ignored", v, 8'h20);
        rd(2'd1, v); check("R6 preset reads 0", v[1], 0);

        // R4 stopped with ticks enabled
        wr(2'd0, 8'h08);
        repeat (50) @(negedge clk);
        rd(2'd3, v); check("R4 stopped holds", v, 8'h20);

        // R3 running with ticks disabled
        wr(2'd0, 8'h00);
        wr(2'd1, 8'h01);
        repeat (50) @(negedge clk);
        rd(2'd3, v); check("R3 gated holds", v, 8'h20);
        wr(2'd1, 8'h00);

        // R2 sweep over every rate code
        for (int k = 0; k < 8; k++) begin
            wr(2'd2, 8'h02);
            wr(2'd1, 8'h02);
            wr(2'd0, 8'(k) | 8'h08);
            wr(2'd1, 8'h01);
            wait_uf();
            uf_gap(n); check($sformatf("R2 period k=%0d", k), n, 3 * (2 << k));
            uf_gap(n); check($sformatf("R2 period2 k=%0d", k), n, 3 * (2 << k));
            wr(2'd1, 8'h00);
        end

        // R5 reload on underflow, one-cycle pulse
        wr(2'd2, 8'h03);
        wr(2'd0, 8'h0F);
        wr(2'd1, 8'h03);
        wait_uf();
        @(negedge clk);
        check("R5 pulse width", uf_pulse, 0);
        rd(2'd3, v); check("R5 reload not wrap", v, 8'h03);
        wr(2'd1, 8'h00);

        // R9 toggle on underflow with output enabled
        wr(2'd2, 8'h02);
        wr(2'd0, 8'h08);
        wr(2'd1, 8'h05);
        wait_uf(); o1 = tmr_out;
        wait_uf(); o2 = tmr_out;
        check("R9 toggles", o1 ^ o2, 1);
        wait_uf(); check("R9 toggles again", tmr_out, o1);
        wr(2'd1, 8'h01);
        wait_uf(); check("R9 forced low", tmr_out, 0);
        wait_uf(); check("R9 forced low 2", tmr_out, 0);

        // R7 restart while running
        wr(2'd2, 8'h09);
        @(negedge clk);
        bus_addr = 2'd1; bus_wdata = 8'h03; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
        uf_gap(n);
        total++;
        if (n < 19 || n > 21) begin
            bad++;
            $display("FAIL R7 restart gap: actual=%0d expected=%0d", n, 20);
        end

        // R8 held read stays frozen while counting
        wr(2'd2, 8'hFF);
        wr(2'd1, 8'h03);
        @(negedge clk);
        bus_addr = 2'd3; bus_re = 1'b1;
        #1 v = bus_rdata;
        repeat (12) @(negedge clk);
        #1 v2 = bus_rdata;
        check("R8 frozen read", v2, v);
        bus_re = 1'b0;
        repeat (4) @(negedge clk);
        rd(2'd3, v2);
        check("R8 buffer follows", (v2 != v) ? 1 : 0, 1);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule